// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block holds a set of small control registers for a workstation I/O controller. A host reaches them over a simple synchronous register bus. Each request names one register through a 3-bit select, and for the 32-bit system-control word a 2-bit byte offset. Each register is accessed at its natural width, and write data is taken from the low bits of the bus. The bus has no back-pressure: every request presented with `req_valid` is accepted in that cycle. A read answers one cycle later with `rsp_valid` high for one cycle. Writes produce no response.

Several registers have side effects beyond storage:
- The auxiliary byte fires a terminal-count pulse toward a floppy controller.
- The power-control byte keeps a power-fail flag and can request a shutdown. The flag is set only while the configuration register's enable bit is set, and it drives the interrupt.
- The system-control word requests a soft reset and records that a reset was requested.
- Any write to the CPU-idle select asserts a halt strobe.

There are two reset inputs:
- A cold reset clears everything.
- A soft block reset clears only the configuration, auxiliary, power-control and modem-control registers.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `irq` is high exactly when the stored power-fail flag is 1 and enable bit 3 of the configuration register is 1. It follows a configuration write or a flag change from the cycle after the edge that updated the register.
- R2: `pwr_fail_in` passes through two synchronising flops. On the third rising edge after it changes, the flag becomes (input level AND configuration bit 3). Between changes the flag holds.
- R3: On a power-control write (select 5), data bit 0 is stored as the power-off bit. If data bit 1 is 1, the flag is cleared. Otherwise the flag keeps its value. This register reads back with bit 5 = flag, bit 0 = power-off bit and all other bits 0.
- R4: A power-control write with data bit 0 = 1 gives a one-cycle `shutdown_req` pulse in the cycle after the write.
- R5: An auxiliary write (select 4) with data bit 1 = 1 gives a one-cycle `tc_pulse` in the cycle after the write. Bit 1 always reads as 0. The other seven bits are stored and read back.
- R6: A system-control write (select 6, offset 0) with data bit 0 = 1 sets the word to 0x00000002 and gives a one-cycle `reset_req` pulse. A write with bit 0 = 0 leaves the word unchanged. At any offset other than 0, writes are ignored and reads return 0.
- R7: A write of any data to the CPU-idle select (7) gives a one-cycle `halt_req` pulse. A read of it returns 0.
- R8: While `soft_rst` is high, the configuration, auxiliary, power-control (flag included) and modem-control registers are cleared. The diagnostic, LED and system-control registers keep their values, and bus requests in that cycle are ignored.
- R9: While `rst_cold_n` is low, every register and every output is cleared to 0.
- R10: A read gives `rsp_valid` = 1 in the next cycle, with `rsp_rdata` holding the stored value zero-extended, and has no side effect.
  - Selects: 0 configuration, 1 diagnostic, 2 modem control, 3 LED (16 bits), 4 auxiliary, 5 power control, 6 system control, 7 CPU idle.
  - Configuration, diagnostic and modem-control bytes store all 8 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Synchronous active-low cold reset |
| soft_rst | input | 1 | Synchronous active-high selective block reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select |
| req_offset | input | 2 | Byte offset within the system-control word |
| req_wdata | input | 32 | Write data |
| pwr_fail_in | input | 1 | Asynchronous power-fail indication |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count strobe |
| shutdown_req | output | 1 | Soft power-off strobe |
| reset_req | output | 1 | Soft reset request strobe |
| halt_req | output | 1 | CPU halt strobe |

## Verification
The bench drives the following patterns, each aimed at one part of the behaviour:

- **Write then read on each select.** Walking patterns such as 0xA5, 0x5A and 0xFF tell the plain storing registers apart from the masked ones. The auxiliary byte drops bit 1 and the power byte keeps only bits 0 and 5.
- **Power-fail input under both enable states.** Toggling the input with the enable bit set and with it clear separates the gated, held flag from the raw input. A clear write issued while the input is still high shows that the clear wins until the next input change.
- **System-control writes.** Writes with bit 0 clear, at non-zero offsets and with bit 0 set distinguish a no-op from the reset-status store.
- **Soft reset after every register is loaded.** This separates the four registers that are cleared from the three that keep their values.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  typedef enum logic [2:0] {
    SEL_CFG   = 3'd0,
    SEL_DIAG  = 3'd1,
    SEL_MODEM = 3'd2,
    SEL_LED   = 3'd3,
    SEL_AUX   = 3'd4,
    SEL_PWR   = 3'd5,
    SEL_SYS   = 3'd6,
    SEL_IDLE  = 3'd7
  } reg_sel_e;

  localparam int BYTE_W       = 8;
  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX_TC_BIT   = 1;
  localparam int PWR_OFF_BIT  = 0;
  localparam int PWR_CLR_BIT  = 1;
  localparam int PWR_FLAG_BIT = 5;
  localparam int SYS_RST_BIT  = 0;
  localparam int SYS_STAT_BIT = 1;
endpackage

// File: rtl/aux_pf_sync.sv
module aux_pf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_out,
  output logic change_out
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign level_out  = chain[STAGES-1];
  assign change_out = chain[STAGES-1] ^ prev_q;
endmodule

// File: rtl/aux_pwr_ctl.sv
module aux_pwr_ctl
  import aux_sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              pie,
  input  logic              pf_level,
  input  logic              pf_change,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] pwr_q,
  output logic              shutdown,
  output logic              irq
);
  logic flag_q, off_q;
  logic flag_evt, flag_d;

  always_comb begin
    flag_evt = pf_change ? (pf_level & pie) : flag_q;
    flag_d   = (wr_en && wr_data[PWR_CLR_BIT]) ? 1'b0 : flag_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      flag_q   <= 1'b0;
      off_q    <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      shutdown <= wr_en & wr_data[PWR_OFF_BIT];
      if (wr_en) off_q <= wr_data[PWR_OFF_BIT];
    end
  end

  always_comb begin
    pwr_q               = '0;
    pwr_q[PWR_FLAG_BIT] = flag_q;
    pwr_q[PWR_OFF_BIT]  = off_q;
  end

  assign irq = flag_q & pie;

  assert_flag_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(pie) && $past(pf_level));

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_data[PWR_CLR_BIT]) |-> !flag_q);

  assert_shutdown_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> $past(wr_en && wr_data[PWR_OFF_BIT] && !soft_rst));
endmodule

// File: rtl/aux_rd_mux.sv
module aux_rd_mux
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16
) (
  input  logic [2:0]        sel,
  input  logic [1:0]        offset,
  input  logic [BYTE_W-1:0] cfg_q,
  input  logic [BYTE_W-1:0] diag_q,
  input  logic [BYTE_W-1:0] modem_q,
  input  logic [LED_W-1:0]  led_q,
  input  logic [BYTE_W-1:0] aux_q,
  input  logic [BYTE_W-1:0] pwr_q,
  input  logic [DATA_W-1:0] sys_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(sel))
      SEL_CFG:   rdata[BYTE_W-1:0] = cfg_q;
      SEL_DIAG:  rdata[BYTE_W-1:0] = diag_q;
      SEL_MODEM: rdata[BYTE_W-1:0] = modem_q;
      SEL_LED:   rdata[LED_W-1:0]  = led_q;
      SEL_AUX:   rdata[BYTE_W-1:0] = aux_q;
      SEL_PWR:   rdata[BYTE_W-1:0] = pwr_q;
      SEL_SYS:   rdata = (offset == 2'd0) ? sys_q : '0;
      SEL_IDLE:  rdata = '0;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LED_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_cold_n,
  input  logic              soft_rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_sel,
  input  logic [1:0]        req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              pwr_fail_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq,
  output logic              tc_pulse,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              halt_req
);
  localparam logic [DATA_W-1:0] SYS_STATUS = DATA_W'(1) << SYS_STAT_BIT;
  localparam logic [BYTE_W-1:0] AUX_KEEP   = ~(BYTE_W'(1) << AUX_TC_BIT);

  logic [BYTE_W-1:0] cfg_q, diag_q, modem_q, aux_q, pwr_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q, mux_data;
  logic              wr, rd, pf_level, pf_change;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(req_sel);
  assign wr  = req_valid &  req_write & ~soft_rst;
  assign rd  = req_valid & ~req_write & ~soft_rst;

  aux_pf_sync #(.STAGES(SYNC_STAGES)) u_pf_sync (
    .clk        (clk),
    .rst_n      (rst_cold_n),
    .async_in   (pwr_fail_in),
    .level_out  (pf_level),
    .change_out (pf_change)
  );

  aux_pwr_ctl u_pwr (
    .clk       (clk),
    .rst_n     (rst_cold_n),
    .soft_rst  (soft_rst),
    .pie       (cfg_q[CFG_PIE_BIT]),
    .pf_level  (pf_level),
    .pf_change (pf_change),
    .wr_en     (wr && sel == SEL_PWR),
    .wr_data   (req_wdata[BYTE_W-1:0]),
    .pwr_q     (pwr_q),
    .shutdown  (shutdown_req),
    .irq       (irq)
  );

  // registers cleared by the soft block reset
  always_ff @(posedge clk) begin
    if (!rst_cold_n || soft_rst) begin
      cfg_q    <= '0;
      modem_q  <= '0;
      aux_q    <= '0;
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= wr && sel == SEL_AUX && req_wdata[AUX_TC_BIT];
      if (wr && sel == SEL_CFG)   cfg_q   <= req_wdata[BYTE_W-1:0];
      if (wr && sel == SEL_MODEM) modem_q <= req_wdata[BYTE_W-1:0];
      if (wr && sel == SEL_AUX)   aux_q   <= req_wdata[BYTE_W-1:0] & AUX_KEEP;
    end
  end

  // registers kept across the soft block reset
  always_ff @(posedge clk) begin
    if (!rst_cold_n) begin
      diag_q <= '0;
      led_q  <= '0;
      sys_q  <= '0;
    end else begin
      if (wr && sel == SEL_DIAG) diag_q <= req_wdata[BYTE_W-1:0];
      if (wr && sel == SEL_LED)  led_q  <= req_wdata[LED_W-1:0];
      if (wr && sel == SEL_SYS && req_offset == 2'd0 && req_wdata[SYS_RST_BIT])
        sys_q <= SYS_STATUS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_cold_n || soft_rst) begin
      reset_req <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      reset_req <= wr && sel == SEL_SYS && req_offset == 2'd0 && req_wdata[SYS_RST_BIT];
      halt_req  <= wr && sel == SEL_IDLE;
    end
  end

  aux_rd_mux #(.DATA_W(DATA_W), .LED_W(LED_W)) u_mux (
    .sel     (req_sel),
    .offset  (req_offset),
    .cfg_q   (cfg_q),
    .diag_q  (diag_q),
    .modem_q (modem_q),
    .led_q   (led_q),
    .aux_q   (aux_q),
    .pwr_q   (pwr_q),
    .sys_q   (sys_q),
    .rdata   (mux_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_cold_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= mux_data;
    end
  end

  assert_irq_cause_R1: assert property (@(posedge clk) disable iff (!rst_cold_n)
    $rose(irq) |-> $past(pf_change || (wr && sel == SEL_CFG)));

  assert_irq_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_cold_n)
    irq |-> cfg_q[CFG_PIE_BIT]);

  assert_tc_src_R5: assert property (@(posedge clk) disable iff (!rst_cold_n)
    tc_pulse |-> $past(req_valid && req_write && !soft_rst && req_sel == 3'd4 && req_wdata[AUX_TC_BIT]));

  assert_tc_not_stored_R5: assert property (@(posedge clk) disable iff (!rst_cold_n)
    !aux_q[AUX_TC_BIT]);

  assert_reset_status_R6: assert property (@(posedge clk) disable iff (!rst_cold_n)
    reset_req |-> sys_q == SYS_STATUS);

  assert_halt_src_R7: assert property (@(posedge clk) disable iff (!rst_cold_n)
    halt_req |-> $past(req_valid && req_write && !soft_rst && req_sel == 3'd7));

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_cold_n)
    $past(soft_rst) |-> cfg_q == '0 && aux_q == '0 && modem_q == '0 && pwr_q == '0);

  assert_soft_keep_R8: assert property (@(posedge clk) disable iff (!rst_cold_n)
    $past(soft_rst) |-> $stable(diag_q) && $stable(sys_q) && $stable(led_q));

  assert_rsp_src_R10: assert property (@(posedge clk) disable iff (!rst_cold_n)
    rsp_valid |-> $past(req_valid && !req_write && !soft_rst));
endmodule

// File: tb/aux_sysctl_regs_tb.sv
module aux_sysctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_cold_n = 1'b0, soft_rst = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_sel = '0;
  logic [1:0]  req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        pwr_fail_in = 1'b0;
  logic        rsp_valid, irq, tc_pulse, shutdown_req, reset_req, halt_req;
  logic [31:0] rsp_rdata;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  aux_sysctl_regs u_dut (
    .clk(clk), .rst_cold_n(rst_cold_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
    .req_offset(req_offset), .req_wdata(req_wdata), .pwr_fail_in(pwr_fail_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq),
    .tc_pulse(tc_pulse), .shutdown_req(shutdown_req), .reset_req(reset_req),
    .halt_req(halt_req)
  );

  // behavioural reference model
  logic [7:0]  m_cfg, m_diag, m_mdm, m_aux;
  logic [15:0] m_led;
  logic [31:0] m_sys, e_rd;
  logic        m_off, m_flag, m_s1, m_s2, m_prev;
  logic        e_tc, e_sd, e_rr, e_halt, e_rv;

  function automatic logic [31:0] model_read(input logic [2:0] s, input logic [1:0] o);
    case (s)
      3'd0: return {24'd0, m_cfg};
      3'd1: return {24'd0, m_diag};
      3'd2: return {24'd0, m_mdm};
      3'd3: return {16'd0, m_led};
      3'd4: return {24'd0, m_aux};
      3'd5: return {26'd0, m_flag, 4'd0, m_off};
      3'd6: return (o == 2'd0) ? m_sys : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic nflag;
    if (!rst_cold_n) begin
      m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux = 0; m_led = 0; m_sys = 0;
      m_off = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      e_tc = 0; e_sd = 0; e_rr = 0; e_halt = 0; e_rv = 0; e_rd = 0;
    end else begin
      nflag = (m_s2 != m_prev) ? (m_s2 & m_cfg[3]) : m_flag;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pwr_fail_in;
      e_tc = 0; e_sd = 0; e_rr = 0; e_halt = 0; e_rv = 0;
      if (soft_rst) begin
        m_cfg = 0; m_mdm = 0; m_aux = 0; m_off = 0; m_flag = 0;
      end else if (req_valid && !req_write) begin
        e_rv = 1; e_rd = model_read(req_sel, req_offset);
        m_flag = nflag;
      end else begin
        m_flag = nflag;
        if (req_valid) begin
          case (req_sel)
            3'd0: m_cfg = req_wdata[7:0];
            3'd1: m_diag = req_wdata[7:0];
            3'd2: m_mdm = req_wdata[7:0];
            3'd3: m_led = req_wdata[15:0];
            3'd4: begin m_aux = req_wdata[7:0] & 8'hFD; e_tc = req_wdata[1]; end
            3'd5: begin
              if (req_wdata[1]) m_flag = 0;
              m_off = req_wdata[0]; e_sd = req_wdata[0];
            end
            3'd6: if (req_offset == 2'd0 && req_wdata[0]) begin m_sys = 32'h2; e_rr = 1; end
            default: e_halt = 1;
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_cold_n) begin
      chk("R1 irq", {31'd0, irq}, {31'd0, m_flag & m_cfg[3]});
      chk("R5 tc_pulse", {31'd0, tc_pulse}, {31'd0, e_tc});
      chk("R4 shutdown_req", {31'd0, shutdown_req}, {31'd0, e_sd});
      chk("R6 reset_req", {31'd0, reset_req}, {31'd0, e_rr});
      chk("R7 halt_req", {31'd0, halt_req}, {31'd0, e_halt});
      chk("R10 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
      if (e_rv) chk("R10 rsp_rdata", rsp_rdata, e_rd);
    end
  end

  task automatic wr(input logic [2:0] s, input logic [1:0] o, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_sel = s; req_offset = o; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [1:0] o, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_sel = s; req_offset = o;
    @(negedge clk);
    req_valid = 0;
    chk(tag, rsp_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below 20000", cyc);
      finish_run();
    end
  end

  initial begin
    idle(3);
    // R9: cold reset state
    chk("R9 outputs in reset", {26'd0, irq, tc_pulse, shutdown_req, reset_req, halt_req, rsp_valid}, 32'd0);
    @(negedge clk); rst_cold_n = 1;
    rd(3'd0, 0, 32'h0, "R9 cfg after cold reset");
    rd(3'd6, 0, 32'h0, "R9 sys after cold reset");

    // R10: plain storage
    wr(3'd0, 0, 32'hA5); rd(3'd0, 0, 32'hA5, "R10 cfg");
    wr(3'd1, 0, 32'h5A); rd(3'd1, 0, 32'h5A, "R10 diag");
    wr(3'd2, 0, 32'hFF); rd(3'd2, 0, 32'hFF, "R10 modem");
    wr(3'd3, 0, 32'hBEEF1234); rd(3'd3, 0, 32'h1234, "R10 led");

    // R5: terminal count bit
    wr(3'd4, 0, 32'hFF); rd(3'd4, 0, 32'hFD, "R5 aux masks bit1");
    wr(3'd4, 0, 32'h40); rd(3'd4, 0, 32'h40, "R5 aux no pulse");

    // R2/R1: power fail with enable set (cfg bit3)
    wr(3'd0, 0, 32'h08);
    @(negedge clk); pwr_fail_in = 1; idle(5);
    chk("R1 irq raised", {31'd0, irq}, 32'd1);
    rd(3'd5, 0, 32'h20, "R2 flag set");
    // R3: clear while input still high
    wr(3'd5, 0, 32'h02); rd(3'd5, 0, 32'h00, "R3 clear wins");
    chk("R1 irq cleared", {31'd0, irq}, 32'd0);
    @(negedge clk); pwr_fail_in = 0; idle(5);
    // R2: enable clear, input rising leaves flag 0
    wr(3'd0, 0, 32'h00);
    @(negedge clk); pwr_fail_in = 1; idle(5);
    rd(3'd5, 0, 32'h00, "R2 flag gated by enable");
    wr(3'd0, 0, 32'h08);
    chk("R1 enable alone no irq", {31'd0, irq}, 32'd0);
    @(negedge clk); pwr_fail_in = 0; idle(5);
    @(negedge clk); pwr_fail_in = 1; idle(5);
    // R3: merge keeps flag, power-off stored; R4 pulse
    wr(3'd5, 0, 32'hFD); rd(3'd5, 0, 32'h21, "R3 merge and off bit");
    wr(3'd5, 0, 32'h00); rd(3'd5, 0, 32'h20, "R3 off bit cleared");

    // R6: system control
    wr(3'd6, 0, 32'hFFFFFFFE); rd(3'd6, 0, 32'h0, "R6 bit0 clear no change");
    wr(3'd6, 2'd1, 32'h1); rd(3'd6, 0, 32'h0, "R6 offset write ignored");
    wr(3'd6, 0, 32'h1); rd(3'd6, 0, 32'h2, "R6 reset status");
    rd(3'd6, 2'd2, 32'h0, "R6 offset read zero");

    // R7: CPU idle
    wr(3'd7, 0, 32'h0); rd(3'd7, 0, 32'h0, "R7 idle reads zero");

    // R8: soft reset
    wr(3'd2, 0, 32'h33); wr(3'd4, 0, 32'h11);
    @(negedge clk); soft_rst = 1; req_valid = 1; req_write = 1; req_sel = 3'd1; req_wdata = 32'h77;
    @(negedge clk); soft_rst = 0; req_valid = 0; req_write = 0;
    rd(3'd0, 0, 32'h0, "R8 cfg cleared");
    rd(3'd2, 0, 32'h0, "R8 modem cleared");
    rd(3'd4, 0, 32'h0, "R8 aux cleared");
    rd(3'd5, 0, 32'h0, "R8 power cleared");
    rd(3'd1, 0, 32'h5A, "R8 diag kept, write ignored");
    rd(3'd3, 0, 32'h1234, "R8 led kept");
    rd(3'd6, 0, 32'h2, "R8 sys kept");
    @(negedge clk); pwr_fail_in = 0;
    idle(6);
    finish_run();
  end
endmodule